// File: doc/BRIEF.md
# Adaptive Promotion Threshold Controller

This block tunes the miss-count threshold that a hybrid memory controller uses to decide when a row should be promoted from the slow, dense memory into the fast DRAM cache. It does not decide promotions itself. It watches three event strobes: a migration was carried out, a read was served by DRAM, and a write was served by DRAM. It counts these events over a measurement interval that the surrounding logic closes with a one-cycle pulse.

At each interval end the controller weighs the cycles spent moving data against the cycles saved by serving requests from DRAM instead of the slow memory. The result is a signed net value. A hill-climbing state machine turns that value into a single step of the threshold, up or down. The machine remembers two things: which way it moved last time, and the net value of the previous interval. The new threshold appears one cycle after the pulse and then holds for the whole next interval.

Latencies are parameters given in clock cycles. At a 4 ns clock the defaults are:

- DRAM row miss: 20 cycles.
- Slow-memory read miss: 32 cycles.
- Slow-memory write miss: 92 cycles.
- Migration cost: 100 cycles.

Row hits take the same time on both devices, so they cancel out of the saving. The default gains are therefore 12 cycles per DRAM read and 72 cycles per DRAM write.

The state machine has two states:

- `ST_LAST_UP` is the reset state. It means the most recent step was an increase.
- `ST_LAST_DN` means the most recent step was a decrease.

On an interval end with a negative net value, the machine goes to ST_LAST_UP. If the net value beats the previous one, the machine stays in its current state and steps the same way again. In every other case it crosses to the other state and steps the opposite way.

Top module: `promo_thresh_ctrl`

## Requirements
- R1: While reset is low, and after it is released, the threshold equals TH_INIT (default 4). The machine is in ST_LAST_UP, the stored previous net value is 0, and all three event counts are 0.
- R2: Each cycle with a strobe high adds one to that strobe's count. A pulse on `quantum_end` clears the counts. A strobe that is high in the same cycle as the pulse is counted in the new interval, not the one that is closing.
- R3: The net value is a signed number equal to reads × (SLOW_RD_MISS_CYC − DRAM_MISS_CYC) + writes × (SLOW_WR_MISS_CYC − DRAM_MISS_CYC) − migrations × MIG_COST_CYC. It is computed from the counts of the interval that is closing.
- R4: If the net value is negative at an interval end, the threshold steps up by one and the machine enters ST_LAST_UP. This holds even if the value beats the previous one.
- R5: If the net value is not negative and strictly greater than the stored previous value, the threshold steps the same way as the last step.
- R6: If the net value is not negative and not greater than the stored previous value (equal included), the threshold steps the opposite way to the last step.
- R7: At every interval end the net value just computed replaces the stored previous value.
- R8: The threshold stays between 1 and TH_MAX (default 15). A step past either bound leaves the threshold at the bound, but the direction state still records the step that was intended.
- R9: The threshold changes only on the clock edge where `quantum_end` is high, so it is visible one cycle after the pulse. It moves by at most one per interval and holds steady at all other times.
- R10: Each event count saturates at its all-ones value (CNT_W bits) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mig_evt | input | 1 | One migration completed this cycle |
| dram_rd_evt | input | 1 | One read served by DRAM this cycle |
| dram_wr_evt | input | 1 | One write served by DRAM this cycle |
| quantum_end | input | 1 | One-cycle pulse closing the measurement interval |
| thresh_o | output | TH_W | Current promotion miss threshold |

## Verification
An event strobe driven high in one cycle is captured by its counter at the next rising edge. The threshold, in turn, reflects the closed interval one cycle after the edge on which `quantum_end` is sampled high. The bench drives all inputs on falling edges. At the falling edge where it raises the pulse, it checks that the threshold still holds the old value. At the next falling edge it checks the new value, one full register stage later. Expected thresholds come from hand-traced hill-climbing sequences. These traces include equal net values, clamping at both bounds, a strobe that coincides with the pulse, and saturated counts.

// File: rtl/promo_pkg.sv
package promo_pkg;

    // Direction of the most recent threshold step
    typedef enum logic {
        ST_LAST_UP = 1'b0,
        ST_LAST_DN = 1'b1
    } climb_state_t;

endpackage

// File: rtl/event_ctr.sv
module event_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         evt,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            // a strobe coinciding with the interval end opens the new interval
            cnt <= W'(evt);
        end else if (evt && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/net_eval.sv
module net_eval #(
    parameter int CNT_W  = 16,
    parameter int NET_W  = 30,
    parameter int RD_GAIN  = 12,
    parameter int WR_GAIN  = 72,
    parameter int MIG_COST = 100
) (
    input  logic [CNT_W-1:0]        mig_cnt,
    input  logic [CNT_W-1:0]        rd_cnt,
    input  logic [CNT_W-1:0]        wr_cnt,
    output logic signed [NET_W-1:0] net
);

    logic signed [NET_W-1:0] mig_x, rd_x, wr_x;
    logic signed [NET_W-1:0] gain_rd, gain_wr, cost_mig;
    logic signed [NET_W-1:0] benefit, cost;

    always_comb begin
        mig_x    = NET_W'(mig_cnt);
        rd_x     = NET_W'(rd_cnt);
        wr_x     = NET_W'(wr_cnt);
        gain_rd  = NET_W'(RD_GAIN);
        gain_wr  = NET_W'(WR_GAIN);
        cost_mig = NET_W'(MIG_COST);
        benefit  = (rd_x * gain_rd) + (wr_x * gain_wr);
        cost     = mig_x * cost_mig;
        net      = benefit - cost;
    end

endmodule

// File: rtl/thresh_fsm.sv
module thresh_fsm
    import promo_pkg::*;
#(
    parameter int NET_W   = 30,
    parameter int TH_MAX  = 15,
    parameter int TH_INIT = 4,
    parameter int TH_W    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    quantum_end,
    input  logic signed [NET_W-1:0] net,
    output logic [TH_W-1:0]         thresh
);

    localparam logic [TH_W-1:0] TH_TOP  = TH_W'(TH_MAX);
    localparam logic [TH_W-1:0] TH_BOT  = TH_W'(1);
    localparam logic [TH_W-1:0] TH_RST  = TH_W'(TH_INIT);

    climb_state_t            state, state_nx;
    logic signed [NET_W-1:0] prev_net;
    logic [TH_W-1:0]         thresh_nx;

    // state register and remembered net value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_LAST_UP;
            prev_net <= '0;
        end else if (quantum_end) begin
            state    <= state_nx;
            prev_net <= net;
        end
    end

    // hill-climbing transition
    always_comb begin
        state_nx = state;
        if (net < 0) begin
            state_nx = ST_LAST_UP;
        end else if (net > prev_net) begin
            state_nx = state;
        end else begin
            unique case (state)
                ST_LAST_UP: state_nx = ST_LAST_DN;
                ST_LAST_DN: state_nx = ST_LAST_UP;
                default:    state_nx = ST_LAST_UP;
            endcase
        end
    end

    // clamped step in the chosen direction
    always_comb begin
        thresh_nx = thresh;
        unique case (state_nx)
            ST_LAST_UP: thresh_nx = (thresh >= TH_TOP) ? TH_TOP : thresh + 1'b1;
            ST_LAST_DN: thresh_nx = (thresh <= TH_BOT) ? TH_BOT : thresh - 1'b1;
            default:    thresh_nx = thresh;
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thresh <= TH_RST;
        end else if (quantum_end) begin
            thresh <= thresh_nx;
        end
    end

endmodule

// File: rtl/promo_thresh_ctrl.sv
module promo_thresh_ctrl
    import promo_pkg::*;
#(
    parameter int CNT_W            = 16,
    parameter int COST_W           = 12,
    parameter int DRAM_MISS_CYC    = 20,
    parameter int SLOW_RD_MISS_CYC = 32,
    parameter int SLOW_WR_MISS_CYC = 92,
    parameter int MIG_COST_CYC     = 100,
    parameter int TH_MAX           = 15,
    parameter int TH_INIT          = 4,
    parameter int TH_W             = $clog2(TH_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mig_evt,
    input  logic            dram_rd_evt,
    input  logic            dram_wr_evt,
    input  logic            quantum_end,
    output logic [TH_W-1:0] thresh_o
);

    localparam int NET_W   = CNT_W + COST_W + 2;
    localparam int RD_GAIN = SLOW_RD_MISS_CYC - DRAM_MISS_CYC;
    localparam int WR_GAIN = SLOW_WR_MISS_CYC - DRAM_MISS_CYC;

    logic [CNT_W-1:0]        mig_cnt, rd_cnt, wr_cnt;
    logic signed [NET_W-1:0] net_val;

    event_ctr #(.W(CNT_W)) u_mig_ctr (
        .clk(clk), .rst_n(rst_n), .clr(quantum_end), .evt(mig_evt), .cnt(mig_cnt)
    );
    event_ctr #(.W(CNT_W)) u_rd_ctr (
        .clk(clk), .rst_n(rst_n), .clr(quantum_end), .evt(dram_rd_evt), .cnt(rd_cnt)
    );
    event_ctr #(.W(CNT_W)) u_wr_ctr (
        .clk(clk), .rst_n(rst_n), .clr(quantum_end), .evt(dram_wr_evt), .cnt(wr_cnt)
    );

    net_eval #(
        .CNT_W(CNT_W), .NET_W(NET_W),
        .RD_GAIN(RD_GAIN), .WR_GAIN(WR_GAIN), .MIG_COST(MIG_COST_CYC)
    ) u_net (
        .mig_cnt(mig_cnt), .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .net(net_val)
    );

    thresh_fsm #(
        .NET_W(NET_W), .TH_MAX(TH_MAX), .TH_INIT(TH_INIT), .TH_W(TH_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .quantum_end(quantum_end),
        .net(net_val), .thresh(thresh_o)
    );

endmodule

// File: rtl/promo_thresh_chk.sv
module promo_thresh_chk #(
    parameter int TH_MAX = 15,
    parameter int TH_W   = 4,
    parameter int NET_W  = 30,
    parameter int CNT_W  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    quantum_end,
    input logic                    dram_rd_evt,
    input logic [CNT_W-1:0]        rd_cnt,
    input logic signed [NET_W-1:0] net_val,
    input logic [TH_W-1:0]         thresh_o
);

    p_bounds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(thresh_o) >= 1) && (int'(thresh_o) <= TH_MAX));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !quantum_end |=> $stable(thresh_o));

    p_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        quantum_end |=> ((int'(thresh_o) - int'($past(thresh_o)) <= 1) &&
                         (int'($past(thresh_o)) - int'(thresh_o) <= 1)));

    p_neg_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (quantum_end && (net_val < 0) && (int'(thresh_o) < TH_MAX))
            |=> (int'(thresh_o) == int'($past(thresh_o)) + 1));

    p_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (quantum_end && !dram_rd_evt) |=> (rd_cnt == '0));

endmodule

bind promo_thresh_ctrl promo_thresh_chk #(
    .TH_MAX(TH_MAX), .TH_W(TH_W), .NET_W(NET_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .quantum_end(quantum_end),
    .dram_rd_evt(dram_rd_evt), .rd_cnt(rd_cnt),
    .net_val(net_val), .thresh_o(thresh_o)
);

// File: tb/tb_promo_thresh_ctrl.sv
module tb_promo_thresh_ctrl;

    localparam int TH_W = 4;

    logic clk = 1'b0;
    logic rst_n, mig_evt, dram_rd_evt, dram_wr_evt, quantum_end;
    logic [TH_W-1:0] thresh_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    promo_thresh_ctrl #(.CNT_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .mig_evt(mig_evt),
        .dram_rd_evt(dram_rd_evt), .dram_wr_evt(dram_wr_evt),
        .quantum_end(quantum_end), .thresh_o(thresh_o)
    );

    typedef struct packed {
        int mig;
        int rd;
        int wr;
        int exp_th;
    } vec_t;

    // gains: read 12, write 72, migration 100; starts at 4, last step up, prev 0
    localparam vec_t VECS [13] = '{
        '{1, 0, 0, 5},   // -100 negative: up (R4)
        '{0, 5, 0, 6},   //   60 > -100: same (R5)
        '{0, 2, 0, 5},   //   24 < 60: reverse (R6)
        '{0, 0, 1, 4},   //   72 > 24: same, down
        '{1, 0, 3, 3},   //  116 > 72 (R3)
        '{1, 10, 2, 2},  //  164 > 116 (R3)
        '{0, 0, 3, 1},   //  216 > 164
        '{0, 0, 4, 1},   //  288: clamp at 1 (R8)
        '{0, 1, 0, 2},   //   12 < 288: reverse to up
        '{0, 0, 0, 1},   //    0 < 12: reverse
        '{0, 0, 0, 2},   //    0 == 0: reverse (R6)
        '{2, 0, 0, 3},   // -200: up
        '{1, 5, 0, 4}    //  -40 > -200 but negative: up (R4)
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // events in separate cycles, then the pulse; checks hold and the update
    task automatic run_quantum(input int m, input int r, input int w,
                               input int exp_th, input string req);
        int span;
        int old_th;
        span = (m > r) ? m : r;
        span = (w > span) ? w : span;
        old_th = int'(thresh_o);
        for (int c = 0; c < span; c++) begin
            mig_evt     = (c < m);
            dram_rd_evt = (c < r);
            dram_wr_evt = (c < w);
            @(negedge clk);
        end
        mig_evt = 1'b0; dram_rd_evt = 1'b0; dram_wr_evt = 1'b0;
        quantum_end = 1'b1;
        check("R9 hold before edge", int'(thresh_o), old_th);
        @(negedge clk);
        quantum_end = 1'b0;
        check(req, int'(thresh_o), exp_th);
    endtask

    initial begin
        rst_n = 1'b0; mig_evt = 1'b0; dram_rd_evt = 1'b0;
        dram_wr_evt = 1'b0; quantum_end = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset value", int'(thresh_o), 4);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", int'(thresh_o), 4);

        for (int i = 0; i < 13; i++) begin
            run_quantum(VECS[i].mig, VECS[i].rd, VECS[i].wr, VECS[i].exp_th,
                        "R3/R4/R5/R6/R7 table");
        end

        // R2: write strobe with the pulse belongs to the next interval
        dram_wr_evt = 1'b1; quantum_end = 1'b1;
        @(negedge clk);
        dram_wr_evt = 1'b0; quantum_end = 1'b0;
        check("R2 closing net 0 > -40", int'(thresh_o), 5);
        run_quantum(0, 0, 0, 6, "R2 coincident write counted next");

        // R8: climb to the top and stay
        for (int k = 7; k <= 15; k++) run_quantum(1, 0, 0, k, "R4 climb");
        run_quantum(1, 0, 0, 15, "R8 clamp at max");
        run_quantum(1, 0, 0, 15, "R8 clamp at max again");
        run_quantum(0, 0, 0, 15, "R8 up recorded, clamp");
        run_quantum(0, 0, 0, 14, "R6 reverse after clamp");

        // R10: saturation at 255 reads
        run_quantum(0, 300, 0, 13, "R10 saturated count 3060");
        run_quantum(0, 255, 0, 14, "R10 R7 equal to stored value");

        // R1: mid-run reset clears direction and previous net value
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid-run reset", int'(thresh_o), 4);
        @(negedge clk);
        run_quantum(0, 0, 0, 3, "R1 R7 prev 0 and up after reset");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule